// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Host Controller

This block connects an on-chip requester to external SRAM or memory-mapped peripherals through one shared 16-bit address/data bus. Three strobes control the bus: an address latch enable (`ale`, active high), a read strobe (`rd_n`, active low) and a write strobe (`wr_n`, active low). The requester presents an address, a direction flag, write data and a width mode while the controller is idle. The controller places the address on the shared pins in one or two latch phases and then releases the pins. It runs a read or write strobe of programmable length. It ends with a one-clock completion pulse that carries the read data.

In wide mode (16-bit devices), a single latch phase carries a 16-bit address. In narrow mode (8-bit devices), the address reach is 24 bits. The upper byte goes out first and the low 16 bits follow in a second latch phase. Data then uses only the low byte lane. The output enable is brought out as a separate pin so that the pad ring can build the tri-state driver. Every transfer takes at least five clocks, so the transfer rate stays below one third of the clock rate.

Top module: `adbus_host`

## Requirements
- R1: After reset the controller is idle: `req_ready`=1, `rd_n`=1, `wr_n`=1, `ale`=0, `ad_oe`=0, `rsp_done`=0.
- R2: In wide mode (`req_wide`=1) there is exactly one `ale` pulse, one clock long, with `ad_out`=addr[15:0]. The pins stay driven and unchanged for one clock after `ale` falls.
- R3: In narrow mode (`req_wide`=0) there are two one-clock `ale` pulses. The first carries {8'h00, addr[23:16]} and the second carries addr[15:0]. Each is held for one clock after `ale` falls.
- R4: For a read, `ad_oe` is 0 for one clock before `rd_n` falls, and `rd_n` stays low for STROBE_CYC clocks. `ad_in` is sampled on the last of those clocks. `rsp_rdata` is `ad_in` in wide mode and {8'h00, ad_in[7:0]} in narrow mode.
- R5: For a write, `wr_n` stays low for STROBE_CYC clocks. During that time `ad_out` is wdata in wide mode or {8'h00, wdata[7:0]} in narrow mode, with `ad_oe`=1. The data stays driven and unchanged for one clock after `wr_n` rises.
- R6: `rsp_done` is a one-clock pulse. Count the clock after the accepting edge as cycle 0. The pulse comes in cycle 3+STROBE_CYC in wide mode and in cycle 5+STROBE_CYC in narrow mode, for both reads and writes. `req_ready` is 1 in the cycle that follows the pulse.
- R7: `rd_n` and `wr_n` are never low together, and `ad_oe` is 0 whenever `rd_n` is low.
- R8: A request is taken only while `req_ready`=1. A `req_valid` raised during a transfer is ignored: it causes no further `ale` pulse and does not change the address in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| req_addr | input | 24 | Target address (upper byte used in narrow mode only) |
| req_wdata | input | 16 | Write data (low byte in narrow mode) |
| req_ready | output | 1 | Controller idle |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ad_out | output | 16 | Value driven onto the shared pins |
| ad_oe | output | 1 | Pin output enable |
| ad_in | input | 16 | Value read from the shared pins |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Each result has a fixed cycle. The completion pulse comes 3+STROBE_CYC clocks after acceptance in wide mode and 5+STROBE_CYC clocks in narrow mode. The bench counts falling edges from the accepting edge and compares that count with the formula. It samples `rsp_rdata` in the same cycle as the pulse. A bus model latches the address at every clock edge where `ale` is high and returns read data that depends on that latched address. The read data therefore shows independently whether the address was sequenced correctly. Strobe widths, the bus turnaround and the extra request raised during a transfer are all measured at the pins, one clock at a time, on falling edges.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALE_U,
    ST_HOLD_U,
    ST_ALE_L,
    ST_HOLD_L,
    ST_TURN,
    ST_RD,
    ST_WR,
    ST_WHOLD,
    ST_DONE
  } adbus_state_e;
endpackage

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_wide,
  input  logic         txn_write,
  output adbus_state_e state,
  output logic         strobe_last
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  adbus_state_e state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic in_strobe;

  assign in_strobe   = (state == ST_RD) || (state == ST_WR);
  assign strobe_last = in_strobe && (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (start) state_d = start_wide ? ST_ALE_L : ST_ALE_U;
      ST_ALE_U:  state_d = ST_HOLD_U;
      ST_HOLD_U: state_d = ST_ALE_L;
      ST_ALE_L:  state_d = ST_HOLD_L;
      ST_HOLD_L: state_d = txn_write ? ST_WR : ST_TURN;
      ST_TURN:   state_d = ST_RD;
      ST_RD:     if (strobe_last) state_d = ST_DONE;
      ST_WR:     if (strobe_last) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = '0;
    if (in_strobe) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      state <= state_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/adbus_regs.sv
module adbus_regs #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              cap_en,
  input  logic              in_write,
  input  logic              in_wide,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] pin_data,
  output logic              txn_write,
  output logic              txn_wide,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [DATA_W-1:0] txn_wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    if (txn_wide) rdata_d = pin_data;
    else          rdata_d = {{(DATA_W-BYTE_W){1'b0}}, pin_data[BYTE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_write <= 1'b0;
      txn_wide  <= 1'b0;
      txn_addr  <= '0;
      txn_wdata <= '0;
    end else if (load_en) begin
      txn_write <= in_write;
      txn_wide  <= in_wide;
      txn_addr  <= in_addr;
      txn_wdata <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/adbus_drive.sv
module adbus_drive
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  adbus_state_e      state,
  input  logic              txn_wide,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [DATA_W-1:0] txn_wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done,
  output logic              ready
);
  localparam int BYTE_W = 8;
  localparam int UP_W   = ADDR_W - DATA_W;

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    unique case (state)
      ST_ALE_U, ST_HOLD_U: begin
        ad_out = {{(DATA_W-UP_W){1'b0}}, txn_addr[ADDR_W-1:DATA_W]};
        ad_oe  = 1'b1;
      end
      ST_ALE_L, ST_HOLD_L: begin
        ad_out = txn_addr[DATA_W-1:0];
        ad_oe  = 1'b1;
      end
      ST_WR, ST_WHOLD: begin
        ad_out = txn_wide ? txn_wdata
                          : {{(DATA_W-BYTE_W){1'b0}}, txn_wdata[BYTE_W-1:0]};
        ad_oe  = 1'b1;
      end
      default: begin
        ad_out = '0;
        ad_oe  = 1'b0;
      end
    endcase
  end

  assign ale   = (state == ST_ALE_U) || (state == ST_ALE_L);
  assign rd_n  = (state != ST_RD);
  assign wr_n  = (state != ST_WR);
  assign done  = (state == ST_DONE);
  assign ready = (state == ST_IDLE);
endmodule

// File: rtl/adbus_host.sv
module adbus_host
  import adbus_pkg::*;
#(
  parameter int STROBE_CYC = 2,
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  adbus_state_e      state;
  logic              strobe_last;
  logic              start;
  logic              cap_en;
  logic              txn_write;
  logic              txn_wide;
  logic [ADDR_W-1:0] txn_addr;
  logic [DATA_W-1:0] txn_wdata;

  assign start  = req_valid && req_ready;
  assign cap_en = (state == ST_RD) && strobe_last;

  adbus_seq #(.STROBE_CYC(STROBE_CYC)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_wide (req_wide),
    .txn_write  (txn_write),
    .state      (state),
    .strobe_last(strobe_last)
  );

  adbus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (start),
    .cap_en   (cap_en),
    .in_write (req_write),
    .in_wide  (req_wide),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .pin_data (ad_in),
    .txn_write(txn_write),
    .txn_wide (txn_wide),
    .txn_addr (txn_addr),
    .txn_wdata(txn_wdata),
    .rdata    (rsp_rdata)
  );

  adbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_drive (
    .state    (state),
    .txn_wide (txn_wide),
    .txn_addr (txn_addr),
    .txn_wdata(txn_wdata),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .done     (rsp_done),
    .ready    (req_ready)
  );
endmodule

// File: rtl/adbus_host_chk.sv
module adbus_host_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_out,
  input logic              rsp_done,
  input logic              req_ready
);
  AST_ALE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe) else $error("ale without drive"); // R2
  AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale) else $error("ale longer than one clock"); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out))) else $error("address not held"); // R2
  AST_RD_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(!ad_oe)) else $error("no turnaround before read"); // R4
  AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe) else $error("write strobe without data"); // R5
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out))) else $error("write data not held"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready)) else $error("done not a pulse"); // R6
  AST_NO_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)) else $error("rd and wr together"); // R7
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe) else $error("contention during read"); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && !ale)) else $error("bus activity while idle"); // R8
endmodule

bind adbus_host adbus_host_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ale      (ale),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .ad_oe    (ad_oe),
  .ad_out   (ad_out),
  .rsp_done (rsp_done),
  .req_ready(req_ready)
);

// File: tb/test_adbus_host.sv
module test_adbus_host;
  localparam int SC = 2;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_wide;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ready, rsp_done, ad_oe, ale, rd_n, wr_n;
  logic [15:0] rsp_rdata, ad_out, ad_in;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adbus_host #(.STROBE_CYC(SC)) i_adbus_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  // bus model
  logic [23:0] lat;
  logic        cur_wide;
  int          ale_cnt, rd_w, wr_w, viol, hold_bad;
  logic [7:0]  first_hi;
  logic [15:0] wr_seen;
  logic        prev_oe, prev_rd_n, prev_wr_n, prev_ale;
  logic [15:0] prev_out;

  function automatic logic [15:0] model_rd(input logic [23:0] a, input logic w);
    if (w) return a[15:0] ^ 16'hA5C3;
    return {8'hC7, a[7:0] ^ a[23:16] ^ 8'h3C};
  endfunction

  assign ad_in = !rd_n ? model_rd(lat, cur_wide) : 16'hBEEF;

  always @(posedge clk) begin
    if (ale) begin
      if (ale_cnt == 0) first_hi = ad_out[15:8];
      lat = {lat[7:0], ad_out};
      ale_cnt = ale_cnt + 1;
    end
    if (!rd_n) rd_w = rd_w + 1;
    if (!wr_n) begin wr_w = wr_w + 1; wr_seen = ad_out; end
    if ((!rd_n && !wr_n) || (!rd_n && ad_oe)) viol = viol + 1;
    if (!rd_n && prev_rd_n && prev_oe) viol = viol + 1;
    if (!ale && prev_ale && !(ad_oe && ad_out == prev_out)) hold_bad = hold_bad + 1;
    if (wr_n && !prev_wr_n && !(ad_oe && ad_out == prev_out)) hold_bad = hold_bad + 1;
    prev_oe = ad_oe; prev_rd_n = rd_n; prev_wr_n = wr_n; prev_ale = ale; prev_out = ad_out;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {write, wide, addr, wdata}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b1, 24'h00_1234, 16'h0000},
    {1'b1, 1'b1, 24'h00_ABCD, 16'h5A5A},
    {1'b0, 1'b0, 24'hC3_0F0F, 16'h0000},
    {1'b1, 1'b0, 24'h7E_8001, 16'hF00D},
    {1'b0, 1'b1, 24'h00_FFFF, 16'h0000},
    {1'b1, 1'b1, 24'h00_0000, 16'hFFFF},
    {1'b0, 1'b0, 24'hFF_FFFF, 16'h0000},
    {1'b1, 1'b0, 24'h01_0000, 16'h00A5}
  };

  task automatic run_txn(input logic wr, input logic wd, input logic [23:0] a,
                         input logic [15:0] d, input bit poke_busy);
    int lat_cyc;
    int exp_lat;
    logic [15:0] exp_rd;
    @(negedge clk);
    ale_cnt = 0; rd_w = 0; wr_w = 0; first_hi = 8'hEE; cur_wide = wd;
    req_valid = 1'b1; req_write = wr; req_wide = wd; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat_cyc = 0;
    while (!rsp_done && lat_cyc < 40) begin
      if (poke_busy && lat_cyc == 1) begin
        req_valid = 1'b1; req_wide = 1'b0; req_write = ~wr; req_addr = 24'h5A5A5A;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      lat_cyc++;
    end
    req_valid = 1'b0;
    exp_lat = (wd ? 3 : 5) + SC;
    check(lat_cyc == exp_lat, "R6 latency", lat_cyc, exp_lat);
    if (wd) begin
      check(ale_cnt == 1, "R2 ale count", ale_cnt, 1);
      check(lat[15:0] == a[15:0], "R2 latched addr", lat[15:0], a[15:0]);
    end else begin
      check(ale_cnt == 2, "R3 ale count", ale_cnt, 2);
      check(lat == a, "R3 latched addr", lat, a);
      check(first_hi == 8'h00, "R3 upper lane zero", first_hi, 0);
    end
    if (wr) begin
      check(wr_w == SC && rd_w == 0, "R5 strobe width", wr_w, SC);
      check(wr_seen == (wd ? d : {8'h00, d[7:0]}), "R5 write data", wr_seen,
            wd ? d : {8'h00, d[7:0]});
    end else begin
      exp_rd = model_rd(a, wd);
      if (!wd) exp_rd = {8'h00, exp_rd[7:0]};
      check(rd_w == SC && wr_w == 0, "R4 strobe width", rd_w, SC);
      check(rsp_rdata == exp_rd, "R4 read data", rsp_rdata, exp_rd);
    end
    @(negedge clk);
    check(req_ready && !rsp_done, "R6 ready after done", {req_ready, rsp_done}, 2'b10);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    lat = '0; ale_cnt = 0; rd_w = 0; wr_w = 0; viol = 0; hold_bad = 0;
    first_hi = 0; wr_seen = 0; cur_wide = 1'b1;
    prev_oe = 0; prev_rd_n = 1; prev_wr_n = 1; prev_ale = 0; prev_out = 0;
    req_valid = 0; req_write = 0; req_wide = 1; req_addr = 0; req_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready && rd_n && wr_n && !ale && !ad_oe && !rsp_done, "R1 reset outputs",
          {req_ready, rd_n, wr_n, ale, ad_oe, rsp_done}, 6'b111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && rd_n && wr_n && !ale && !ad_oe, "R1 idle after release",
          {req_ready, rd_n, wr_n, ale, ad_oe}, 5'b11100);

    for (int i = 0; i < NV; i++)
      run_txn(VEC[i][41], VEC[i][40], VEC[i][39:16], VEC[i][15:0], 1'b0);

    // R8: request raised while busy is ignored
    run_txn(1'b0, 1'b1, 24'h00_4321, 16'h0, 1'b1);
    ale_cnt = 0;
    repeat (4) @(negedge clk);
    check(ale_cnt == 0 && req_ready, "R8 busy request ignored", ale_cnt, 0);
    run_txn(1'b1, 1'b0, 24'h9A_BCDE, 16'h1234, 1'b1);
    ale_cnt = 0;
    repeat (4) @(negedge clk);
    check(ale_cnt == 0 && req_ready, "R8 busy request ignored narrow", ale_cnt, 0);

    // R7 strobes exclusive, bus released during read; R2/R5 hold phases
    check(viol == 0, "R7 strobe/drive conflicts", viol, 0);
    check(hold_bad == 0, "R2 R3 R5 hold after strobe", hold_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule